// File: doc/BRIEF.md
# Power-of-Two Serial Bit-Clock Generator

This block turns a fast reference clock into the bit timing for a serial peripheral master. A bank of parameter words holds one word for each chip select. The word for the currently selected device carries an 8-bit rate code. The remaining three bytes of that word are the chip-select setup count, the chip-select hold count and the gap between transfers. The generator does not use those three counts itself. It passes them to the transfer engine.

While the transfer engine holds `run` high, a 9-bit phase accumulator adds the effective step (1 to 256) on every reference cycle. Each carry out of the accumulator produces a one-cycle `bit_tick`, so the tick rate is the reference rate times step/512. A serial clock, `bit_sclk`, toggles on every tick and so runs at half the tick rate. It starts low, and the transfer engine applies any clock polarity later. The all-ones code stands for a step of 256, which gives a tick on every other reference cycle. A code of zero gives no ticks at all. When `run` is low the accumulator and `bit_sclk` are held clear, so every transaction starts from the same phase.

Top module: `bitclk_gen`

## Requirements
- R1: With a power-of-two rate code E (2 to 128) and `run` held high, `bit_tick` pulses exactly every 512/E reference cycles. The first pulse is registered on the (512/E)-th rising edge at which `run` is sampled high.
- R2: The all-ones code 8'hFF acts as a step of 256: `bit_tick` pulses on every second edge with `run` high.
- R3: Code 8'h01 gives the slowest rate, one `bit_tick` every 512 edges.
- R4: Code 8'h00 produces no `bit_tick` however long `run` is high. A following transaction with a nonzero code runs at its normal rate.
- R5: `bit_sclk` changes only at a tick, or when it is cleared to 0 by idle. It toggles on every tick, starting from 0, so it is high after odd-numbered ticks.
- R6: While `run` is sampled low, the next cycle shows `bit_tick` = 0 and `bit_sclk` = 0, and the phase is cleared. A transaction that was stopped partway through a period therefore restarts with its first tick a full 512/E edges after `run` rises.
- R7: Each parameter word is laid out as rate code [31:24], setup [23:16], hold [15:8] and gap [7:0]. The fields of the word indexed by `cs_sel` appear on `cs_setup`, `cs_hold` and `xfer_gap`, and its code sets the rate.
- R8: After reset every word is zero, `bit_tick` = 0 and `bit_sclk` = 0.
- R9: `bit_tick` is never high on two consecutive cycles.
- R10: A write with `cfg_we` updates only the word at `cfg_idx`, one edge later. The words of all other chip selects keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a parameter word |
| cfg_idx | input | 3 | Chip-select index of the word to write |
| cfg_word | input | 32 | Parameter word to store |
| cs_sel | input | 3 | Chip select whose word is in use |
| run | input | 1 | Transfer engine active; low clears the phase |
| bit_tick | output | 1 | One-cycle pulse at the bit rate |
| bit_sclk | output | 1 | Serial clock at half the tick rate, idle low |
| cs_setup | output | 8 | Setup count of the selected word |
| cs_hold | output | 8 | Hold count of the selected word |
| xfer_gap | output | 8 | Inter-transfer gap of the selected word |

## Verification
The hardest case to reach is a stale accumulator phase. It only shows up when a slow transaction is stopped partway through a period, and with code 1 a single period is 512 cycles. The stimulus runs code 1 for 300 edges, drops `run`, and starts again. The scoreboard then expects the first tick at exactly edge 512 rather than edge 212. A zero-code run of 600 edges, followed at once by a fast transaction, shows that the zero code is silent and that the block does not lock up.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
   localparam int FIELD_W = 8;
   localparam int WORD_W  = 4 * FIELD_W;

   // Field order is fixed: the transfer engine decodes the same layout.
   typedef struct packed {
      logic [FIELD_W-1:0] rate;   // [31:24]
      logic [FIELD_W-1:0] setup;  // [23:16]
      logic [FIELD_W-1:0] hold;   // [15:8]
      logic [FIELD_W-1:0] gap;    // [7:0]
   } devword_t;
endpackage

// File: rtl/devparam_bank.sv
module devparam_bank
   import bitclk_pkg::*;
#(
   parameter int NUM_CS = 5,
   parameter int CS_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CS_W-1:0]     widx,
   input  logic [WORD_W-1:0]   wdata,
   input  logic [CS_W-1:0]     rsel,
   output devword_t            rword
);
   devword_t words [NUM_CS];

   generate
      if (NUM_CS < 2 || (1 << CS_W) < NUM_CS) begin : g_bad_cfg
         $error("devparam_bank: NUM_CS must be >= 2 and fit in CS_W bits");
      end
      for (genvar g = 0; g < NUM_CS; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words[g] <= '0;
            else if (we && widx == CS_W'(g))
               words[g] <= devword_t'(wdata);
         end
      end
   endgenerate

   always_comb begin
      rword = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (rsel == CS_W'(i)) rword = words[i];
   end
endmodule

// File: rtl/scale_decode.sv
module scale_decode #(
   parameter int SCALE_W      = 8,
   parameter bit SAT_ALL_ONES = 1'b1,
   localparam int STEP_W      = SCALE_W + 1
) (
   input  logic [SCALE_W-1:0] code,
   output logic [STEP_W-1:0]  step
);
   localparam logic [STEP_W-1:0] FULL_STEP = STEP_W'(1) << SCALE_W;

   generate
      if (SCALE_W < 2) begin : g_bad_w
         $error("scale_decode: SCALE_W must be at least 2");
      end
      if (SAT_ALL_ONES) begin : g_sat
         always_comb step = (&code) ? FULL_STEP : {1'b0, code};
      end else begin : g_plain
         always_comb step = {1'b0, code};
      end
   endgenerate
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
   parameter int ACC_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [ACC_W-1:0] step,
   output logic             tick,
   output logic             sclk
);
   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;

   generate
      if (ACC_W < 3) begin : g_bad_w
         $error("phase_acc: ACC_W must be at least 3");
      end
   endgenerate

   assign sum = {1'b0, acc} + {1'b0, step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         tick <= 1'b0;
         sclk <= 1'b0;
      end else if (!run) begin
         acc  <= '0;
         tick <= 1'b0;
         sclk <= 1'b0;
      end else begin
         acc  <= sum[ACC_W-1:0];
         tick <= sum[ACC_W];
         sclk <= sclk ^ sum[ACC_W];
      end
   end

   // R9
   tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R4
   zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == '0) |=> !tick);

   // R6
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!tick && !sclk && acc == '0));
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
   import bitclk_pkg::*;
#(
   parameter int NUM_CS       = 5,
   parameter int CS_W         = 3,
   parameter bit SAT_ALL_ONES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CS_W-1:0]      cfg_idx,
   input  logic [WORD_W-1:0]    cfg_word,
   input  logic [CS_W-1:0]      cs_sel,
   input  logic                 run,
   output logic                 bit_tick,
   output logic                 bit_sclk,
   output logic [FIELD_W-1:0]   cs_setup,
   output logic [FIELD_W-1:0]   cs_hold,
   output logic [FIELD_W-1:0]   xfer_gap
);
   localparam int ACC_W = FIELD_W + 1;

   devword_t          cur_word;
   logic [ACC_W-1:0]  step;

   devparam_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .widx  (cfg_idx),
      .wdata (cfg_word),
      .rsel  (cs_sel),
      .rword (cur_word)
   );

   scale_decode #(.SCALE_W(FIELD_W), .SAT_ALL_ONES(SAT_ALL_ONES)) u_dec (
      .code (cur_word.rate),
      .step (step)
   );

   phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (step),
      .tick  (bit_tick),
      .sclk  (bit_sclk)
   );

   assign cs_setup = cur_word.setup;
   assign cs_hold  = cur_word.hold;
   assign xfer_gap = cur_word.gap;

   // R5
   sclk_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_sclk != $past(bit_sclk)) |-> (bit_tick || !bit_sclk));

   // R7 R10
   word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == cs_sel && 32'(cs_sel) < NUM_CS) |=>
         (!$stable(cs_sel) ||
          {cs_setup, cs_hold, xfer_gap} == $past(cfg_word[WORD_W-FIELD_W-1:0])));
endmodule

// File: tb/test_bitclk_gen.sv
`timescale 1ns/1ps
module test_bitclk_gen;
   localparam int NUM_CS = 5;
   localparam int CS_W   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_word = '0;
   logic [2:0]  cs_sel = '0;
   logic        run = 1'b0;
   logic        bit_tick, bit_sclk;
   logic [7:0]  cs_setup, cs_hold, xfer_gap;

   int tests = 0;
   int fails = 0;
   int exp_q[$];
   string cur_req = "R8";
   bit mon_on = 1'b0;
   logic run_at_edge = 1'b0;
   int cnt = 0;
   bit lvl = 1'b0;

   always #2 clk = ~clk;

   bitclk_gen #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_bitclk_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_word(cfg_word), .cs_sel(cs_sel), .run(run),
      .bit_tick(bit_tick), .bit_sclk(bit_sclk),
      .cs_setup(cs_setup), .cs_hold(cs_hold), .xfer_gap(xfer_gap));

   task automatic chk(bit ok, string req, int act, int exp, string what);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_word(int idx, logic [31:0] w);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_word = w;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   // Driver: pushes expected tick edge numbers, then runs the transaction.
   task automatic run_burst(int cs, int period, int nticks, int edges, string req);
      @(posedge clk); #1;
      cur_req = req;
      cs_sel = 3'(cs);
      for (int k = 1; k <= nticks; k++) exp_q.push_back(k * period);
      run = 1'b1;
      repeat (edges) @(posedge clk);
      #1 run = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0, req, exp_q.size(), 0, "pending ticks after burst");
      chk(bit_tick == 1'b0 && bit_sclk == 1'b0, "R6", {bit_tick, bit_sclk}, 0, "idle outputs");
      exp_q.delete();
   endtask

   always @(posedge clk) run_at_edge <= run;

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         if (run_at_edge) cnt++;
         else begin cnt = 0; lvl = 1'b0; end
         if (bit_tick) begin
            lvl = !lvl;
            if (exp_q.size() == 0)
               chk(1'b0, cur_req, cnt, -1, "unexpected tick at edge");
            else begin
               int e;
               e = exp_q.pop_front();
               chk(cnt == e, cur_req, cnt, e, "tick edge number");
            end
            chk(bit_sclk == lvl, "R5", bit_sclk, lvl, "sclk after tick");
         end else begin
            if (exp_q.size() > 0 && cnt >= exp_q[0]) begin
               chk(1'b0, cur_req, cnt, exp_q[0], "missing tick");
               void'(exp_q.pop_front());
            end
            if (bit_sclk != lvl) chk(1'b0, "R5", bit_sclk, lvl, "sclk between ticks");
         end
      end
   end

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk(bit_tick == 1'b0, "R8", bit_tick, 0, "tick after reset");
      chk(bit_sclk == 1'b0, "R8", bit_sclk, 0, "sclk after reset");
      chk({cs_setup, cs_hold, xfer_gap} == 24'h0, "R8", {cs_setup, cs_hold, xfer_gap}, 0, "word after reset");
      mon_on = 1'b1;

      // R7 layout: rate[31:24] setup[23:16] hold[15:8] gap[7:0]
      write_word(0, 32'h80_05_06_07);
      write_word(1, 32'hFF_11_12_13);
      write_word(2, 32'h01_21_22_23);
      write_word(3, 32'h00_31_32_33);
      write_word(4, 32'h40_41_42_43);
      @(posedge clk); #1 cs_sel = 3'd0;
      @(negedge clk);
      chk(cs_setup == 8'h05, "R7", cs_setup, 5, "setup cs0");
      chk(cs_hold == 8'h06, "R7", cs_hold, 6, "hold cs0");
      chk(xfer_gap == 8'h07, "R7", xfer_gap, 7, "gap cs0");
      @(posedge clk); #1 cs_sel = 3'd4;
      @(negedge clk);
      chk({cs_setup, cs_hold, xfer_gap} == 24'h414243, "R7", {cs_setup, cs_hold, xfer_gap}, 24'h414243, "fields cs4");

      // R10 rewrite cs2, others untouched
      write_word(2, 32'h01_AA_BB_CC);
      @(posedge clk); #1 cs_sel = 3'd2;
      @(negedge clk);
      chk({cs_setup, cs_hold, xfer_gap} == 24'hAABBCC, "R10", {cs_setup, cs_hold, xfer_gap}, 24'hAABBCC, "rewritten cs2");
      @(posedge clk); #1 cs_sel = 3'd1;
      @(negedge clk);
      chk({cs_setup, cs_hold, xfer_gap} == 24'h111213, "R10", {cs_setup, cs_hold, xfer_gap}, 24'h111213, "cs1 kept");

      // R1 code 0x80 -> period 4; code 0x40 -> period 8
      run_burst(0, 4, 8, 32, "R1");
      run_burst(4, 8, 6, 48, "R1");
      // R2 all-ones -> period 2
      run_burst(1, 2, 10, 20, "R2");
      // R3 code 1 -> period 512
      run_burst(2, 512, 2, 1024, "R3");
      // R4 code 0 silent, then recovery
      run_burst(3, 1, 0, 600, "R4");
      run_burst(0, 4, 5, 20, "R4");
      // R6 partial slow phase, then restart must wait full period
      run_burst(2, 512, 0, 300, "R6");
      run_burst(2, 512, 1, 512, "R6");

      mon_on = 1'b0;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule